// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C bus target that lets an external host read and write a small register bank inside the chip. It runs in the system clock domain and oversamples SCL and SDA through two-flop synchronizers. It finds start, repeated-start and stop conditions, then compares the first byte with its fixed 7-bit device address. SDA is open-drain: the block reports a pull-low enable and never drives the line high.

A write transfer carries a register pointer byte, followed by any number of data bytes. Each data byte lands at the current pointer, and the pointer then moves up by one. A read transfer streams bytes out of the bank, starting at the current pointer. It moves to the next register each time the host acknowledges and stops when the host declines. The pointer is 8 bits wide and keeps its value between transfers. A host can therefore set the pointer with a short write, issue a repeated start and read from that register.

The register bank sits outside the block. The block presents an address, write data and a one-cycle write strobe, and it expects the read data to follow the address within the same cycle.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth clock) a first byte whose upper seven bits equal the device address 0x5A. Bit 0 of that byte selects the direction, 0 for write and 1 for read, so the wire bytes are 0xB4 and 0xB5.
- R2: A first byte carrying any other address is never acknowledged. SDA stays released and no register is written until the next start condition.
- R3: In a write transfer, the first byte after the address byte is acknowledged and loaded into the register pointer.
- R4: Each further byte of a write transfer is acknowledged and written to the register at the current pointer, after which the pointer advances by one. This continues until a stop or repeated start.
- R5: A read transfer returns the register at the current pointer, most significant bit first. It returns the next register after each byte the host acknowledges.
- R6: When the host does not acknowledge a read byte, the block releases SDA and does not drive it again, even if the host keeps clocking, until a stop or start.
- R7: The 8-bit pointer wraps from 0xFF to 0x00 in both write and read bursts.
- R8: The pointer keeps its value across stop and repeated start. A read that follows a pointer-only write, or that follows another read, starts at the register where the pointer was left.
- R9: The SDA pull-low enable changes only while SCL is low.
- R10: Every register write is a strobe lasting exactly one system clock, with address and data valid in that cycle.
- R11: After reset, SDA is released, the write strobe is low and the register address is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | PTR_W | Register bank address (current pointer) |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register bank read data for reg_addr |

## Verification
The bench builds the block with its defaults: device address 0x5A and an 8-bit pointer. With a 256-entry bank model, two-byte bursts starting at 0xFE and 0xFF, and a four-byte read that crosses 0xFF, the pointer wrap is reached in both directions. The same defaults let 0xB6, one bit away from the write address, serve as the mismatching address. A host model that keeps clocking after its own NACK shows whether the block really stays silent.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h5A,
  parameter int         PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);

  localparam logic [3:0] LAST_BIT = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RD} st_t;

  logic [2:0]       scl_p, sda_p;
  logic             scl_s, scl_q, sda_s;
  logic             start_c, stop_c, rise, fall;
  st_t              st;
  logic [3:0]       bcnt;
  logic [7:0]       sr, tx;
  logic [PTR_W-1:0] ptr;
  logic             rw, in_ack, nack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  assign scl_s   = scl_p[1];
  assign scl_q   = scl_p[2];
  assign sda_s   = sda_p[1];
  assign start_c = scl_s & scl_q & sda_p[2] & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_p[2] & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;

  assign reg_addr  = ptr;
  assign reg_wdata = sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      bcnt   <= '0;
      sr     <= '0;
      tx     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      in_ack <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (start_c) begin
        st     <= S_ADDR;
        bcnt   <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_PTR, S_WR: begin
            if (rise && !in_ack && bcnt < LAST_BIT) begin
              sr   <= {sr[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (fall && !in_ack && bcnt == LAST_BIT) begin
              in_ack <= 1'b1;
              sda_oe <= 1'b1;
              if (st == S_ADDR) begin
                rw <= sr[0];
                if (sr[7:1] != DEV_ADDR) begin
                  st     <= S_IDLE;
                  in_ack <= 1'b0;
                  sda_oe <= 1'b0;
                end
              end else if (st == S_PTR) begin
                ptr <= sr[PTR_W-1:0];
              end else begin
                reg_we <= 1'b1;
              end
            end else if (fall && in_ack) begin
              in_ack <= 1'b0;
              bcnt   <= '0;
              sda_oe <= 1'b0;
              if (st == S_ADDR) begin
                if (rw) begin
                  st     <= S_RD;
                  tx     <= reg_rdata;
                  sda_oe <= ~reg_rdata[7];
                end else begin
                  st <= S_PTR;
                end
              end else if (st == S_PTR) begin
                st <= S_WR;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end
          end
          S_RD: begin
            if (rise) begin
              if (in_ack) nack <= sda_s;
              else        bcnt <= bcnt + 4'd1;
            end else if (fall) begin
              if (!in_ack) begin
                if (bcnt == LAST_BIT) begin
                  sda_oe <= 1'b0;
                  in_ack <= 1'b1;
                  ptr    <= ptr + 1'b1;
                end else begin
                  tx     <= {tx[6:0], 1'b0};
                  sda_oe <= ~tx[6];
                end
              end else begin
                in_ack <= 1'b0;
                bcnt   <= '0;
                if (nack) begin
                  st <= S_IDLE;
                end else begin
                  tx     <= reg_rdata;
                  sda_oe <= ~reg_rdata[7];
                end
              end
            end
          end
          default: ;
        endcase
      end
    end

  p_sda_change_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  p_we_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_we_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sda_oe);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  p_start_rearms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == S_ADDR && bcnt == 4'd0 && !sda_oe));

  p_nack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && in_ack && fall && nack && !start_c && !stop_c) |=> (st == S_IDLE && !sda_oe));

endmodule

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       sda;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;

  logic [7:0] mem [256];
  logic [7:0] exp_m [256];
  int         checks = 0, fails = 0, we_cnt = 0, r9_viol = 0, r10_viol = 0;
  logic       prev_oe = 1'b0, prev_we = 1'b0;

  always #10 clk = ~clk;

  assign sda       = ~(m_low | sda_oe);
  assign reg_rdata = mem[reg_addr];

  i2c_reg_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (rst_n && sda_oe != prev_oe && scl) r9_viol <= r9_viol + 1;
    if (reg_we && prev_we) r10_viol <= r10_viol + 1;
    prev_oe <= sda_oe;
    prev_we <= reg_we;
  end

  // {pointer, first data, second data}
  localparam logic [23:0] VEC [6] = '{
    24'h00_A5_3C, 24'h10_01_80, 24'h7F_FF_00,
    24'hFE_12_34, 24'hFF_9A_BC, 24'h40_55_AA
  };

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw();
  endtask

  task automatic bit_cycle(input logic b, output logic seen);
    m_low = ~b; qw(); scl = 1'b1; qw(); seen = sda; qw(); scl = 1'b0; qw();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack_n);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(d[i], s);
    bit_cycle(1'b1, ack_n);
    m_low = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      d[i] = s;
    end
    bit_cycle(~give_ack, s);
    m_low = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic       a0, a1, a2, a3;
    logic [7:0] d0, d1, d2, d3;
    int         w0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      exp_m[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 reg_we", reg_we, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reg_addr", reg_addr, 0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] p, x0, x1;
      {p, x0, x1} = VEC[v];
      w0 = we_cnt;
      bus_start();
      put_byte(8'hB4, a0); put_byte(p, a1); put_byte(x0, a2); put_byte(x1, a3);
      bus_stop();
      exp_m[p] = x0;
      exp_m[8'(p + 1)] = x1;
      chk("R1 R3 R4 write acks", {a0, a1, a2, a3}, 0);
      chk("R4 write count", we_cnt - w0, 2);
      chk("R4 R7 stored first", mem[p], exp_m[p]);
      chk("R4 R7 stored second", mem[8'(p + 1)], exp_m[8'(p + 1)]);
      bus_start();
      put_byte(8'hB4, a0); put_byte(p, a1);
      bus_start();
      put_byte(8'hB5, a2);
      get_byte(1'b1, d0); get_byte(1'b0, d1);
      bus_stop();
      chk("R1 R8 read setup acks", {a0, a1, a2}, 0);
      chk("R5 read first", d0, exp_m[p]);
      chk("R5 R7 read second", d1, exp_m[8'(p + 1)]);
    end

    // R2: wrong address, following bytes must neither be acked nor written
    w0 = we_cnt;
    bus_start();
    put_byte(8'hB6, a0); put_byte(8'h20, a1); put_byte(8'h77, a2);
    bus_stop();
    chk("R2 no ack on mismatch", {a0, a1, a2}, 3'b111);
    chk("R2 no write on mismatch", we_cnt - w0, 0);
    chk("R2 register untouched", mem[8'h20], exp_m[8'h20]);

    // R8: pointer-only write, stop, then a fresh read transfer
    bus_start();
    put_byte(8'hB4, a0); put_byte(8'h10, a1);
    bus_stop();
    bus_start();
    put_byte(8'hB5, a2); get_byte(1'b0, d0);
    bus_stop();
    chk("R8 pointer kept across stop", d0, exp_m[8'h10]);
    bus_start();
    put_byte(8'hB5, a3); get_byte(1'b0, d1);
    bus_stop();
    chk("R8 read continues after earlier read", d1, exp_m[8'h11]);

    // R5 R7: long read crossing 0xFF
    bus_start();
    put_byte(8'hB4, a0); put_byte(8'hFE, a1);
    bus_start();
    put_byte(8'hB5, a2);
    get_byte(1'b1, d0); get_byte(1'b1, d1); get_byte(1'b1, d2); get_byte(1'b0, d3);
    bus_stop();
    chk("R5 R7 burst read", {d0, d1, d2, d3},
        {exp_m[8'hFE], exp_m[8'hFF], exp_m[8'h00], exp_m[8'h01]});

    // R6: after host NACK, further clocks see a released line
    bus_start();
    put_byte(8'hB4, a0); put_byte(8'h7F, a1);
    bus_start();
    put_byte(8'hB5, a2);
    get_byte(1'b0, d0);
    get_byte(1'b1, d1);
    bus_stop();
    chk("R6 nack byte value", d0, exp_m[8'h7F]);
    chk("R6 line released after nack", d1, 8'hFF);

    chk("R9 sda changes only with scl low", r9_viol, 0);
    chk("R10 single-cycle strobes", r10_viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule